// File: doc/BRIEF.md
# Multi-Cycle Integer Divider

This block divides one WIDTH-bit integer by another and returns both the quotient and the remainder. It works one quotient bit per clock. A single 2·WIDTH-bit working register keeps the partial remainder in its upper half and the quotient bits already formed in its lower half. A mode input picks plain unsigned division or two's-complement signed division. In signed mode the block divides the magnitudes of the operands. After the loop it sets the signs so that the quotient truncates toward zero and a nonzero remainder takes the sign of the dividend.

The caller gives a one-cycle start pulse together with the operands and the mode. A one-cycle done pulse comes back with the results, which stay on the outputs until the next result arrives. A start that comes while a division is in flight is dropped. A zero divisor raises no fault: it gives a fixed, predictable result.

Top module: `intdiv_top`

## Requirements
- R1: While reset is held and after it is released, done_o is 0 and quotient_o and remainder_o are 0 until the first division completes.
- R2: A start_i sampled high at a clock edge while the block is idle is accepted. done_o is then high for exactly one cycle, starting WIDTH+1 clock edges after the accepting edge.
- R3: With signed_i = 0 (unsigned mode) and a nonzero divisor, quotient_o = floor(a/b) and remainder_o = a − quotient·b, both unsigned.
- R4: With signed_i = 1 (two's-complement mode) and a nonzero divisor, quotient_o is the true quotient truncated toward zero. It is negative when the two operand sign bits differ.
- R5: In signed mode, a nonzero remainder has the sign of the dividend, and its magnitude is less than that of the divisor.
- R6: In signed mode, the most negative value divided by −1 gives quotient_o equal to the most negative value and remainder_o equal to 0.
- R7: In unsigned mode, a zero divisor gives quotient_o all ones and remainder_o equal to the dividend.
- R8: In signed mode, a zero divisor gives remainder_o equal to the dividend. quotient_o is 1 when the dividend is negative, and all ones (−1) otherwise.
- R9: A start_i pulse that comes after an accepted start and before its done_o is ignored. Its operands have no effect on the result or the latency of the division in flight.
- R10: quotient_o and remainder_o change only in the cycle in which done_o is high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse; accepted only when idle |
| signed_i | input | 1 | 1 = two's-complement division, 0 = unsigned |
| dividend_i | input | WIDTH | Dividend, sampled on the accepting edge |
| divisor_i | input | WIDTH | Divisor, sampled on the accepting edge |
| done_o | output | 1 | One-cycle pulse when results are updated |
| quotient_o | output | WIDTH | Quotient of the most recent division |
| remainder_o | output | WIDTH | Remainder of the most recent division |

## Verification
The assertions take for granted that dividend_i, divisor_i and signed_i are only meaningful on the edge where a start is accepted. They also assume reset is held long enough to clear the in-flight state. The checker captures the operands on that edge and checks each result only against that capture. The stimulus drives start_i as a single-cycle pulse. It changes operands only on falling edges, so nothing is sampled while it is changing. It waits for done_o before it issues the next accepted start, except in the deliberate mid-flight start that exercises R9.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } div_mode_e;

    typedef struct packed {
        logic neg_quot;
        logic neg_rem;
    } sign_fix_t;

endpackage

// File: rtl/intdiv_prep.sv
module intdiv_prep
    import intdiv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             mode_i,
    input  logic [WIDTH-1:0] num_i,
    input  logic [WIDTH-1:0] den_i,
    output logic [WIDTH-1:0] num_mag_o,
    output logic [WIDTH-1:0] den_mag_o,
    output sign_fix_t        fix_o
);
    localparam int MSB = WIDTH - 1;

    div_mode_e mode;
    logic      num_neg;
    logic      den_neg;

    always_comb begin
        mode    = div_mode_e'(mode_i);
        num_neg = (mode == MODE_SIGNED) && num_i[MSB];
        den_neg = (mode == MODE_SIGNED) && den_i[MSB];
        num_mag_o = num_neg ? (~num_i + 1'b1) : num_i;
        den_mag_o = den_neg ? (~den_i + 1'b1) : den_i;
        fix_o.neg_quot = num_neg ^ den_neg;
        fix_o.neg_rem  = num_neg;
    end
endmodule

// File: rtl/intdiv_core.sv
module intdiv_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] num_i,
    input  logic [WIDTH-1:0] den_i,
    output logic             run_o,
    output logic             fin_o,
    output logic [WIDTH-1:0] quot_o,
    output logic [WIDTH-1:0] rem_o
);
    localparam int DW = 2 * WIDTH;
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [DW-1:0]    work_q;
    logic [WIDTH-1:0] den_q;
    logic [CW-1:0]    cnt_q;
    logic             run_q;
    logic             fin_q;

    logic [DW-1:0]    shifted;
    logic [WIDTH+1:0] trial;
    logic             borrow;
    logic [DW-1:0]    work_d;

    always_comb begin
        shifted = {work_q[DW-2:0], 1'b0};
        trial   = {1'b0, work_q[DW-1:WIDTH-1]} - {2'b00, den_q};
        borrow  = trial[WIDTH+1];
        work_d  = borrow ? shifted
                         : {trial[WIDTH-1:0], shifted[WIDTH-1:1], 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            fin_q  <= 1'b0;
        end else if (load_i) begin
            work_q <= {{WIDTH{1'b0}}, num_i};
            den_q  <= den_i;
            cnt_q  <= '0;
            run_q  <= 1'b1;
            fin_q  <= 1'b0;
        end else if (run_q) begin
            work_q <= work_d;
            if (cnt_q == LAST) begin
                run_q <= 1'b0;
                fin_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign run_o  = run_q;
    assign fin_o  = fin_q;
    assign quot_o = work_q[WIDTH-1:0];
    assign rem_o  = work_q[DW-1:WIDTH];
endmodule

// File: rtl/intdiv_fix.sv
module intdiv_fix
    import intdiv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  sign_fix_t        fix_i,
    input  logic [WIDTH-1:0] quot_mag_i,
    input  logic [WIDTH-1:0] rem_mag_i,
    output logic [WIDTH-1:0] quot_o,
    output logic [WIDTH-1:0] rem_o
);
    always_comb begin
        quot_o = fix_i.neg_quot ? (~quot_mag_i + 1'b1) : quot_mag_i;
        rem_o  = fix_i.neg_rem  ? (~rem_mag_i + 1'b1)  : rem_mag_i;
    end
endmodule

// File: rtl/intdiv_top.sv
module intdiv_top
    import intdiv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             done_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o
);
    logic             core_run;
    logic             core_fin;
    logic             busy_w;
    logic             accept;
    logic [WIDTH-1:0] num_mag;
    logic [WIDTH-1:0] den_mag;
    sign_fix_t        fix_now;
    sign_fix_t        fix_q;
    logic [WIDTH-1:0] quot_mag;
    logic [WIDTH-1:0] rem_mag;
    logic [WIDTH-1:0] quot_fixed;
    logic [WIDTH-1:0] rem_fixed;

    assign busy_w = core_run | core_fin;
    assign accept = start_i & ~busy_w;

    intdiv_prep #(.WIDTH(WIDTH)) prep_i (
        .mode_i    (signed_i),
        .num_i     (dividend_i),
        .den_i     (divisor_i),
        .num_mag_o (num_mag),
        .den_mag_o (den_mag),
        .fix_o     (fix_now)
    );

    intdiv_core #(.WIDTH(WIDTH)) core_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .num_i  (num_mag),
        .den_i  (den_mag),
        .run_o  (core_run),
        .fin_o  (core_fin),
        .quot_o (quot_mag),
        .rem_o  (rem_mag)
    );

    intdiv_fix #(.WIDTH(WIDTH)) fix_i (
        .fix_i      (fix_q),
        .quot_mag_i (quot_mag),
        .rem_mag_i  (rem_mag),
        .quot_o     (quot_fixed),
        .rem_o      (rem_fixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fix_q       <= '0;
            done_o      <= 1'b0;
            quotient_o  <= '0;
            remainder_o <= '0;
        end else begin
            if (accept) fix_q <= fix_now;
            done_o <= core_fin;
            if (core_fin) begin
                quotient_o  <= quot_fixed;
                remainder_o <= rem_fixed;
            end
        end
    end
endmodule

// File: rtl/intdiv_chk.sv
module intdiv_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             signed_i,
    input logic [WIDTH-1:0] dividend_i,
    input logic [WIDTH-1:0] divisor_i,
    input logic             done_o,
    input logic [WIDTH-1:0] quotient_o,
    input logic [WIDTH-1:0] remainder_o,
    input logic             busy
);
    localparam int DW = 2 * WIDTH;

    logic             past_ok;
    logic             active;
    logic [31:0]      since;
    logic             cap_mode;
    logic [WIDTH-1:0] cap_a;
    logic [WIDTH-1:0] cap_b;
    logic [DW-1:0]    recon;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok  <= 1'b0;
            active   <= 1'b0;
            since    <= '0;
            cap_mode <= 1'b0;
            cap_a    <= '0;
            cap_b    <= '0;
        end else begin
            past_ok <= 1'b1;
            if (start_i && !busy) begin
                active   <= 1'b1;
                since    <= '0;
                cap_mode <= signed_i;
                cap_a    <= dividend_i;
                cap_b    <= divisor_i;
            end else if (done_o) begin
                active <= 1'b0;
            end else if (active) begin
                since <= since + 1;
            end
        end
    end

    assign recon = DW'(quotient_o) * DW'(cap_b) + DW'(remainder_o);

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (active && since == 32'(WIDTH + 1)));

    a_r3_unsigned_identity: assert property (@(posedge clk) disable iff (rst)
        (done_o && !cap_mode && cap_b != '0) |->
            (recon == DW'(cap_a) && remainder_o < cap_b));

    a_r5_rem_sign: assert property (@(posedge clk) disable iff (rst)
        (done_o && cap_mode && remainder_o != '0) |->
            (remainder_o[WIDTH-1] == cap_a[WIDTH-1]));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o)));
endmodule

bind intdiv_top intdiv_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .signed_i    (signed_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .done_o      (done_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .busy        (busy_w)
);

// File: tb/intdiv_top_tb_top.sv
`timescale 1ns/1ps
module intdiv_top_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic         done_o;
    logic [W-1:0] quotient_o;
    logic [W-1:0] remainder_o;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    intdiv_top #(.WIDTH(W)) dut_i (
        .clk (clk), .rst (rst), .start_i (start_i), .signed_i (signed_i),
        .dividend_i (dividend_i), .divisor_i (divisor_i),
        .done_o (done_o), .quotient_o (quotient_o), .remainder_o (remainder_o)
    );

    // {mode, dividend, divisor}; mode 1 = signed
    localparam logic [2*W:0] VECS [0:11] = '{
        {1'b0, 8'd100, 8'd7},   {1'b0, 8'd255, 8'd1},
        {1'b0, 8'd5,   8'd9},   {1'b0, 8'd200, 8'd200},
        {1'b0, 8'd255, 8'd128}, {1'b0, 8'd129, 8'd255},
        {1'b1, 8'h9c,  8'd7},   {1'b1, 8'd100, 8'hf9},
        {1'b1, 8'h9c,  8'hf9},  {1'b1, 8'h81,  8'h7f},
        {1'b1, 8'h05,  8'hfe},  {1'b1, 8'h80,  8'h02}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ref_div(input logic [W-1:0] a, input logic [W-1:0] b, input logic m,
                           output logic [W-1:0] q, output logic [W-1:0] r);
        longint sa, sb;
        if (b == '0) begin
            r = a;
            q = (m && a[W-1]) ? W'(1) : '1;
        end else if (!m) begin
            q = a / b;
            r = a % b;
        end else begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            q = W'(sa / sb);
            r = W'(sa % sb);
        end
    endtask

    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input logic m,
                           input string tag_in, input bit poke_mid);
        logic [W-1:0] eq, er;
        int cyc;
        string tq, tr;
        ref_div(a, b, m, eq, er);
        if (tag_in != "") begin tq = tag_in; tr = tag_in; end
        else if (b == '0) begin tq = m ? "R8" : "R7"; tr = tq; end
        else begin tq = m ? "R4" : "R3"; tr = m ? "R5" : "R3"; end
        start_i = 1'b1; signed_i = m; dividend_i = a; divisor_i = b;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 40) begin
            if (poke_mid && cyc == 3) begin
                start_i = 1'b1; signed_i = ~m; dividend_i = ~a; divisor_i = b + 8'd3;
            end
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        check("R2 latency", cyc, W + 1);
        check({tq, " quotient"}, quotient_o, eq);
        check({tr, " remainder"}, remainder_o, er);
        @(negedge clk);
        check("R2 done width", done_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        check("R1 done in reset", done_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", done_o, 0);
        check("R1 quotient after reset", quotient_o, 0);
        check("R1 remainder after reset", remainder_o, 0);

        for (int i = 0; i < 12; i++)
            run_div(VECS[i][W-1+W:W], VECS[i][W-1:0], VECS[i][2*W], "", 1'b0);

        run_div(8'h80, 8'hff, 1'b1, "R6", 1'b0);
        run_div(8'd77, 8'd0, 1'b0, "R7", 1'b0);
        run_div(8'h90, 8'd0, 1'b1, "R8", 1'b0);
        run_div(8'd33, 8'd0, 1'b1, "R8", 1'b0);
        run_div(8'd0, 8'd0, 1'b0, "R7", 1'b0);

        // R9: mid-flight start with different operands is dropped
        run_div(8'd201, 8'd13, 1'b0, "R9", 1'b1);

        // R10: outputs hold after done
        run_div(8'd250, 8'd6, 1'b0, "", 1'b0);
        repeat (3) @(negedge clk);
        check("R10 quotient hold", quotient_o, 8'd41);
        check("R10 remainder hold", remainder_o, 8'd4);
        check("R10 done stays low", done_o, 0);

        lfsr = 16'hace1;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_div(lfsr[7:0], (k % 5 == 0) ? {4'h0, lfsr[11:8]} : lfsr[15:8], k[0], "", 1'b0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule